// File: doc/BRIEF.md
# Scalar Double Move-Merge Writeback Unit

This unit computes the writeback for a scalar 64-bit move, load or store to a vector register. The decode stage supplies several inputs:

- the current destination register value;
- two register sources, or a 64-bit memory datum;
- an encoding class and an operation form;
- the low writemask bit, with mask-present and zeroing controls;
- a 4-bit register-specifier field.

From these, the unit produces the next register value with a write enable, the datum and enable for a store, and an undefined-opcode fault.

The class and form decide what happens to the bits above the scalar lane. Those bits are kept from the old destination, copied from the first source, or cleared. In the masked class, the low lane can also be merged with the old value or zeroed. The unit has one register stage, and each accepted input produces its result one clock later with `out_valid` set.

Top module: `sd_move_merge`

## Requirements
- R1: Legacy class (`enc`=0) with register form (`form`=0): result bits 63:0 equal `src2`[63:0], and every bit above 63 equals `dst_old`.
- R2: Legacy class with load form (`form`=1): bits 63:0 equal `mem_data`, bits 127:64 are zero, and bits 128 and up equal `dst_old`.
- R3: Plain vector class (`enc`=1) or masked class (`enc`=2) with register form: bits 63:0 come from `src2`, bits 127:64 from `src1`, and bits 128 and up are zero.
- R4: Class 1 or 2 with load form: bits 63:0 equal `mem_data`, and all bits from 64 up are zero.
- R5: In class 2, when `mask_present`=1 and `mask_bit0`=0, the low 64 bits of a register or load result keep `dst_old`[63:0] if `zeroing`=0 and are zero if `zeroing`=1. The upper bits still follow R3 or R4.
- R6: Store form (`form`=2) raises `st_en` with `st_data`=`src2`[63:0] and never raises `reg_we`. In class 2, a store with `mask_present`=1 and `mask_bit0`=0 keeps `st_en` low, whatever the value of `zeroing`.
- R7: In class 1 or 2, a load or store with `vvvv`!=4'hF raises `ud_fault` and keeps `reg_we` and `st_en` low in the same cycle. `reg_result` then equals `dst_old`. The legacy class ignores `vvvv`.
- R8: `enc`=3 (reserved) or `form`=3 (memory-to-memory) always raises `ud_fault`, with both write enables low.
- R9: `zeroing` has no effect in classes 0 and 1, or when `mask_present`=0. Those cases write the low lane as unmasked.
- R10: After reset, `out_valid`, `reg_we`, `st_en` and `ud_fault` are low. Each input with `in_valid`=1 shows its result one clock later. With `in_valid`=0, the outputs the next cycle show `out_valid`, `reg_we` and `st_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| in_valid | input | 1 | input operation valid |
| enc | input | 2 | class: 0 legacy, 1 plain vector, 2 masked, 3 reserved |
| form | input | 2 | 0 register merge, 1 load, 2 store, 3 memory-to-memory |
| vvvv | input | 4 | register specifier field, must be 4'hF for class 1/2 load/store |
| mask_present | input | 1 | a writemask is applied (class 2 only) |
| mask_bit0 | input | 1 | writemask bit zero |
| zeroing | input | 1 | 1 zeroing masking, 0 merging masking |
| dst_old | input | VLEN | current destination value |
| src1 | input | VLEN | first register source (upper lane donor) |
| src2 | input | VLEN | second register source (scalar value, store source) |
| mem_data | input | 64 | loaded memory datum |
| out_valid | output | 1 | result valid |
| reg_we | output | 1 | register write enable |
| reg_result | output | VLEN | new destination value |
| st_en | output | 1 | memory store enable |
| st_data | output | 64 | store datum |
| ud_fault | output | 1 | undefined-opcode fault |

## Verification
The unit has no state beyond its single output stage. A wrong choice of lane source, upper-bit policy or enable therefore appears at the ports on the very next cycle after the offending input. The bench compares every output of that cycle with a model built from the requirements. A lost mask decision or fault gating shows as a spurious `reg_we` or `st_en` on that same cycle. An enable held over from an earlier input shows on a following idle cycle.

// File: rtl/sd_move_merge.sv
module sd_move_merge #(
  parameter int VLEN = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      enc,
  input  logic [1:0]      form,
  input  logic [3:0]      vvvv,
  input  logic            mask_present,
  input  logic            mask_bit0,
  input  logic            zeroing,
  input  logic [VLEN-1:0] dst_old,
  input  logic [VLEN-1:0] src1,
  input  logic [VLEN-1:0] src2,
  input  logic [63:0]     mem_data,
  output logic            out_valid,
  output logic            reg_we,
  output logic [VLEN-1:0] reg_result,
  output logic            st_en,
  output logic [63:0]     st_data,
  output logic            ud_fault
);
  localparam logic [1:0] C_LEG = 2'd0, C_VEX = 2'd1, C_MSK = 2'd2, C_RSV = 2'd3;
  localparam logic [1:0] F_RR = 2'd0, F_LD = 2'd1, F_ST = 2'd2, F_MM = 2'd3;

  logic            is_vec, fault, masked_off;
  logic [63:0]     lo_new, lo;
  logic [VLEN-1:0] res;

  assign is_vec     = (enc == C_VEX) || (enc == C_MSK);
  assign fault      = (enc == C_RSV) || (form == F_MM) ||
                      (is_vec && form != F_RR && vvvv != 4'hF);
  assign masked_off = (enc == C_MSK) && mask_present && !mask_bit0;
  assign lo_new     = (form == F_LD) ? mem_data : src2[63:0];
  assign lo         = masked_off ? (zeroing ? 64'd0 : dst_old[63:0]) : lo_new;

  always_comb begin
    res = dst_old;
    if (!fault) begin
      if (form == F_RR) begin
        if (is_vec) begin
          res          = '0;
          res[127:64]  = src1[127:64];
        end
        res[63:0] = lo;
      end else if (form == F_LD) begin
        if (is_vec) res = '0;
        else        res[127:64] = 64'd0;
        res[63:0] = lo;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      reg_we     <= 1'b0;
      st_en      <= 1'b0;
      ud_fault   <= 1'b0;
      reg_result <= '0;
      st_data    <= '0;
    end else begin
      out_valid  <= in_valid;
      reg_we     <= in_valid && !fault && form != F_ST;
      st_en      <= in_valid && !fault && form == F_ST && !masked_off;
      ud_fault   <= in_valid && fault;
      reg_result <= res;
      st_data    <= src2[63:0];
    end
  end
endmodule

// File: rtl/sd_move_merge_chk.sv
module sd_move_merge_chk #(
  parameter int VLEN = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      enc,
  input logic [1:0]      form,
  input logic [3:0]      vvvv,
  input logic [VLEN-1:0] dst_old,
  input logic            out_valid,
  input logic            reg_we,
  input logic            st_en,
  input logic            ud_fault,
  input logic [VLEN-1:0] reg_result
);
  p_fault_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> (!reg_we && !st_en));

  p_store_no_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> !reg_we);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!reg_we && !st_en && !ud_fault));

  p_vvvv_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (enc == 2'd1 || enc == 2'd2) && (form == 2'd1 || form == 2'd2) && vvvv != 4'hF)
    |=> ud_fault);

  p_reserved_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (enc == 2'd3 || form == 2'd3)) |=> ud_fault);

  p_legacy_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc == 2'd0 && form == 2'd0)
    |=> reg_result[VLEN-1:64] == $past(dst_old[VLEN-1:64]));

  p_vec_load_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (enc == 2'd1 || enc == 2'd2) && form == 2'd1 && vvvv == 4'hF)
    |=> (reg_result[VLEN-1:64] == '0 && reg_we));
endmodule

bind sd_move_merge sd_move_merge_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc(enc), .form(form),
  .vvvv(vvvv), .dst_old(dst_old), .out_valid(out_valid), .reg_we(reg_we),
  .st_en(st_en), .ud_fault(ud_fault), .reg_result(reg_result)
);

// File: tb/sim_sd_move_merge.sv
module sim_sd_move_merge;
  localparam int VL = 512;
  localparam int CLK_PERIOD = 10;

  logic          clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0]    enc = 0, form = 0;
  logic [3:0]    vvvv = 4'hF;
  logic          mask_present = 0, mask_bit0 = 0, zeroing = 0;
  logic [VL-1:0] dst_old = '0, src1 = '0, src2 = '0;
  logic [63:0]   mem_data = '0;
  logic          out_valid, reg_we, st_en, ud_fault;
  logic [VL-1:0] reg_result;
  logic [63:0]   st_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_move_merge #(.VLEN(VL)) u0 (.*);

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic string tag_of(logic [1:0] e, logic [1:0] f, logic [3:0] v,
                                   logic mp, logic m0);
    if (e == 3 || f == 3) return "R8";
    if (e != 0 && f != 0 && v != 4'hF) return "R7";
    if (f == 2) return "R6";
    if (e == 2 && mp && !m0) return "R5";
    if (e == 0) return (f == 0) ? "R1" : "R2";
    return (f == 0) ? "R3" : "R4";
  endfunction

  task automatic apply(input logic [1:0] e, input logic [1:0] f, input logic [3:0] v,
                       input logic mp, input logic m0, input logic z, input string tag);
    logic          flt, moff, x_we, x_st;
    logic [63:0]   lane;
    logic [VL-1:0] x_res;
    @(negedge clk);
    enc = e; form = f; vvvv = v; mask_present = mp; mask_bit0 = m0; zeroing = z;
    dst_old = rnd_vec(); src1 = rnd_vec(); src2 = rnd_vec();
    mem_data = {$urandom, $urandom};
    in_valid = 1;
    flt  = (e == 3) || (f == 3) || (e != 0 && f != 0 && v != 4'hF);
    moff = (e == 2) && mp && !m0;
    lane = (f == 1) ? mem_data : src2[63:0];
    if (moff) lane = z ? 64'd0 : dst_old[63:0];
    x_res = dst_old;
    x_we  = !flt && f != 2;
    x_st  = !flt && f == 2 && !moff;
    if (!flt && f == 0 && e == 0) x_res = {dst_old[VL-1:64], lane};
    if (!flt && f == 0 && e != 0) x_res = {{(VL-128){1'b0}}, src1[127:64], lane};
    if (!flt && f == 1 && e == 0) x_res = {dst_old[VL-1:128], 64'd0, lane};
    if (!flt && f == 1 && e != 0) x_res = {{(VL-64){1'b0}}, lane};
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    checks++;
    if (out_valid !== 1 || reg_we !== x_we || st_en !== x_st || ud_fault !== flt ||
        reg_result !== x_res || (x_st && st_data !== src2[63:0])) begin
      errors++;
      $display("FAIL %s enc=%0d form=%0d: we=%b st=%b flt=%b st_data=%h res_lo=%h res_hi=%h | exp we=%b st=%b flt=%b st_data=%h res_lo=%h res_hi=%h",
               tag, e, f, reg_we, st_en, ud_fault, st_data, reg_result[63:0], reg_result[127:64],
               x_we, x_st, flt, src2[63:0], x_res[63:0], x_res[127:64]);
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || reg_we !== 0 || st_en !== 0 || ud_fault !== 0) begin
      errors++;
      $display("FAIL R10 reset: v=%b we=%b st=%b f=%b expected all 0", out_valid, reg_we, st_en, ud_fault);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || reg_we !== 0 || st_en !== 0) begin
      errors++;
      $display("FAIL R10 idle: v=%b we=%b st=%b expected 0", out_valid, reg_we, st_en);
    end

    apply(0, 0, 4'h0, 1, 0, 1, "R1");
    apply(0, 1, 4'h3, 0, 0, 0, "R2");
    apply(1, 0, 4'h5, 0, 0, 0, "R3");
    apply(2, 1, 4'hF, 0, 0, 0, "R4");
    apply(2, 0, 4'hF, 1, 0, 0, "R5");
    apply(2, 1, 4'hF, 1, 0, 1, "R5");
    apply(2, 2, 4'hF, 1, 0, 1, "R6");
    apply(0, 2, 4'h0, 0, 0, 0, "R6");
    apply(1, 2, 4'hE, 0, 0, 0, "R7");
    apply(2, 1, 4'h0, 0, 1, 0, "R7");
    apply(3, 0, 4'hF, 0, 0, 0, "R8");
    apply(0, 3, 4'hF, 0, 0, 0, "R8");
    apply(1, 0, 4'hF, 1, 0, 1, "R9");
    apply(2, 1, 4'hF, 0, 0, 1, "R9");

    @(negedge clk);
    checks++;
    if (out_valid !== 0 || reg_we !== 0 || st_en !== 0) begin
      errors++;
      $display("FAIL R10 idle after ops: v=%b we=%b st=%b expected 0", out_valid, reg_we, st_en);
    end

    for (int n = 0; n < 3000; n++) begin
      logic [1:0] e, f;
      logic [3:0] v;
      logic mp, m0, z;
      e = 2'($urandom_range(0, 3)); f = 2'($urandom_range(0, 3));
      v = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
      mp = 1'($urandom); m0 = 1'($urandom); z = 1'($urandom);
      apply(e, f, v, mp, m0, z, tag_of(e, f, v, mp, m0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule